// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a 32-pin general-purpose I/O bank that sits on a simple memory-mapped word bus. Software gives each pin an output value and a direction. It reads back the synchronized level seen on every pin, whatever the output value register holds.

Each pin can also raise an interrupt. Two independent per-pin bits set the sense of the interrupt:
- The type bit chooses level or edge sensitivity.
- The polarity bit chooses active-low/falling or active-high/rising.

Edge events are held in a latch until software writes a one to the matching bit of the end-of-interrupt register. Level conditions follow the pin and are never latched.

A raw status view shows every pending condition. A masked status view shows only the pins whose enable bit is set. One combined interrupt line is asserted while any masked status bit is set. Pin inputs pass through a two-flop synchronizer before any comparison is made.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output value, direction, enable, type and polarity registers read 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: A write to offset 0x00 sets `pin_out` and a write to offset 0x04 sets `pin_oe` (bit 1 = output, 0 = input), both from the next clock edge. Both registers read back what was written.
- R3: A read at offset 0x50 returns `pin_in` as sampled through two clock edges, regardless of the output value register. Writes to 0x50 change no register.
- R4: When a pin's type bit (offset 0x38) is 0, its raw status bit is 1 while the synchronized pin level equals its polarity bit (offset 0x3C; 0 = active low, 1 = active high). The raw bit follows the pin with no latching and appears three clock edges after the pin changes.
- R5: When a pin's type bit is 1, a change between successive synchronized samples toward its polarity value latches its raw status bit. Polarity 1 selects a rising change and 0 a falling change. The bit stays set after the pin returns, and a change in the other direction does not set it.
- R6: Writing 1 to a bit at offset 0x4C clears that pin's latched edge event. Writing 0 leaves the bit unchanged. Reads of 0x4C return 0.
- R7: If a new edge and an end-of-interrupt write for the same pin take effect on the same clock edge, the edge wins and the raw bit stays 1.
- R8: Offset 0x40 reads raw status AND enable (offset 0x30), and offset 0x44 reads raw status. Clearing an enable bit masks the pin without losing its raw bit or its configuration.
- R9: `irq` is 1 exactly when the masked status is nonzero.
- R10: Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output value register |
| pin_oe | output | 32 | Output enable (direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The two functions that can meet on one clock edge are the capture of a fresh edge and an end-of-interrupt write that clears the same pin. To provoke this, a pin is first left with an event latched. The bench then drives the pin so that its synchronized edge is detected on the same clock edge that samples the end-of-interrupt write. The raw status must still show the bit set. A control run with the write alone shows the bit cleared.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFS_OUTVAL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_TYPE   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_POL    = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_EOI    = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_PINS   = 8'h50;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] itype_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] stat_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] evt;
        logic [W-1:0] lvl;
    } det_t;

    det_t         det_d, det_q;
    logic [W-1:0] hit;

    always_comb begin
        // an edge toward the polarity value, only for edge-typed pins
        hit       = itype_i & (lvl_i ^ det_q.prev) & ~(lvl_i ^ pol_i);
        det_d.prev = lvl_i;
        det_d.evt  = hit | (det_q.evt & ~clr_i & itype_i);
        det_d.lvl  = ~itype_i & ~(lvl_i ^ pol_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign raw_o  = det_q.evt | det_q.lvl;
    assign stat_o = raw_o & en_i;
    assign irq_o  = |stat_o;

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((det_q.evt & ~$past(itype_i)) == '0)); // R4

    AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((det_q.evt & $past(hit)) == $past(hit))); // R7

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((det_q.evt & $past(clr_i & ~hit)) == '0)); // R6

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_i != '0)); // R9
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
    import gpio_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0] outval;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] itype;
        logic [NPINS-1:0] pol;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             wr_en;
    logic [NPINS-1:0] clr, lvl, raw, stat;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(lvl)
    );

    gpio_irq_detect #(.W(NPINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .itype_i(cfg_q.itype),
        .pol_i(cfg_q.pol), .en_i(cfg_q.en), .clr_i(clr),
        .raw_o(raw), .stat_o(stat), .irq_o(irq)
    );

    assign wr_en = bus_sel & bus_wr;
    assign clr   = (wr_en && bus_addr == OFS_EOI) ? bus_wdata : '0;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (bus_addr)
                OFS_OUTVAL: cfg_d.outval = bus_wdata;
                OFS_DIR:    cfg_d.dir    = bus_wdata;
                OFS_ENABLE: cfg_d.en     = bus_wdata;
                OFS_TYPE:   cfg_d.itype  = bus_wdata;
                OFS_POL:    cfg_d.pol    = bus_wdata;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_OUTVAL: bus_rdata = cfg_q.outval;
            OFS_DIR:    bus_rdata = cfg_q.dir;
            OFS_ENABLE: bus_rdata = cfg_q.en;
            OFS_TYPE:   bus_rdata = cfg_q.itype;
            OFS_POL:    bus_rdata = cfg_q.pol;
            OFS_STAT:   bus_rdata = stat;
            OFS_RAW:    bus_rdata = raw;
            OFS_PINS:   bus_rdata = lvl;
            default:    bus_rdata = '0;
        endcase
    end

    assign pin_out = cfg_q.outval;
    assign pin_oe  = cfg_q.dir;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata))); // R2

    AST_PINS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFS_PINS) |=> $stable(cfg_q)); // R3

    AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw != '0)); // R9
endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic        irq;
    int          checks = 0, failures = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive_pins(logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset;
        chk("R1 pin_oe", pin_oe, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        bus_read(8'h30, rd); chk("R1 enable", rd, 32'h0);
        bus_read(8'h3C, rd); chk("R1 polarity", rd, 32'h0);
    endtask

    task automatic t_data_dir;
        bus_write(8'h00, 32'hA5A5_0F0F);
        bus_write(8'h04, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        bus_read(8'h04, rd); chk("R2 dir readback", rd, 32'hFFFF_0000);
    endtask

    task automatic t_ext_port;
        drive_pins(32'h1234_5678);
        bus_read(8'h50, rd); chk("R3 pin levels", rd, 32'h1234_5678);
        bus_write(8'h50, 32'hDEAD_BEEF);
        bus_read(8'h04, rd); chk("R3 write ignored dir", rd, 32'hFFFF_0000);
        bus_read(8'h00, rd); chk("R3 write ignored outval", rd, 32'hA5A5_0F0F);
    endtask

    task automatic t_level;
        bus_write(8'h3C, 32'h0000_0002);
        drive_pins(32'h0000_000A);
        bus_read(8'h44, rd); chk("R4 level raw", rd & 32'hE, 32'h6);
        drive_pins(32'h0000_0008);
        bus_read(8'h44, rd); chk("R4 level no latch", rd & 32'hE, 32'h4);
    endtask

    task automatic t_edge;
        bus_write(8'h3C, 32'h0000_0010);
        bus_write(8'h38, 32'h0000_0030);
        drive_pins(32'h0000_0020);
        bus_read(8'h44, rd); chk("R5 no event yet", rd & 32'h30, 32'h0);
        drive_pins(32'h0000_0010);
        drive_pins(32'h0000_0020);
        bus_read(8'h44, rd); chk("R5 edges latched", rd & 32'h30, 32'h30);
        bus_write(8'h4C, 32'h0000_0010);
        drive_pins(32'h0000_0000);
        bus_read(8'h44, rd); chk("R5 rising pin ignores fall", rd & 32'h30, 32'h20);
    endtask

    task automatic t_eoi;
        bus_write(8'h4C, 32'h0000_0000);
        bus_read(8'h44, rd); chk("R6 zero write no effect", rd & 32'h30, 32'h20);
        bus_read(8'h4C, rd); chk("R6 eoi reads zero", rd, 32'h0);
        bus_write(8'h4C, 32'h0000_0020);
        bus_read(8'h44, rd); chk("R6 eoi clears", rd & 32'h30, 32'h0);
    endtask

    task automatic t_collide;
        drive_pins(32'h0000_0020);
        drive_pins(32'h0000_0000);
        bus_read(8'h44, rd); chk("R7 setup latched", rd & 32'h20, 32'h20);
        drive_pins(32'h0000_0020);
        @(negedge clk);
        pin_in = 32'h0000_0000;
        repeat (2) @(posedge clk);
        bus_write(8'h4C, 32'h0000_0020);
        bus_read(8'h44, rd); chk("R7 edge wins over eoi", rd & 32'h20, 32'h20);
        bus_write(8'h4C, 32'h0000_0020);
        bus_read(8'h44, rd); chk("R7 control eoi alone", rd & 32'h20, 32'h0);
    endtask

    task automatic t_mask_irq;
        bus_write(8'h30, 32'h0000_0010);
        @(negedge clk); chk("R9 irq low idle", {31'h0, irq}, 32'h0);
        drive_pins(32'h0000_0010);
        bus_read(8'h40, rd); chk("R8 status masked", rd, 32'h10);
        chk("R9 irq set", {31'h0, irq}, 32'h1);
        bus_write(8'h30, 32'h0);
        bus_read(8'h40, rd); chk("R8 status when masked", rd, 32'h0);
        chk("R9 irq masked", {31'h0, irq}, 32'h0);
        bus_read(8'h44, rd); chk("R8 raw kept", rd & 32'h10, 32'h10);
        bus_read(8'h38, rd); chk("R8 config kept", rd, 32'h30);
        bus_write(8'h30, 32'h0000_0010);
        @(negedge clk); chk("R9 irq on re-enable", {31'h0, irq}, 32'h1);
        bus_write(8'h4C, 32'h0000_0010);
        chk("R9 irq after eoi", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_unmapped;
        bus_read(8'h20, rd); chk("R10 unmapped 0x20", rd, 32'h0);
        bus_read(8'h48, rd); chk("R10 unmapped 0x48", rd, 32'h0);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_data_dir();
        t_ext_port();
        t_level();
        t_edge();
        t_eoi();
        t_collide();
        t_mask_irq();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule